// File: doc/BRIEF.md
# Supervisor Mode and Reset Sequencer

This block decides the operating mode of a power supervisor and drives the active-low reset that goes to the host processor. After power-up, and after any wake-up from the sleep or stop low-power modes, it enters a temporary request mode. In request mode the main regulator is enabled and the auxiliary regulator is not. While reset is released, a startup timer counts millisecond ticks. The host must write the watchdog configuration register before that timer runs out. The write moves the block to normal mode and loads the external watchdog with the period and window setting just written. If the timer runs out first, the block gives the host a reset pulse and begins request mode again.

Reset is held low for several reasons: while the main supply is below threshold, while a power-on or sleep wake-up is still waiting for the supply to come into range, while a timed reset pulse is running (after a watchdog expiry or a startup timeout), and for the whole time the block is in sleep. A sticky battery-fail flag is also kept. The host reads it through the mode control register, and that read clears it.

Low-power entry comes in as a request that names a target mode. Wake events bring the block out of sleep or stop. Every time interval is counted on a 1 ms tick input, and both limits are parameters.

Top module: `sup_mode_seq`

## Requirements
- R1: After synchronous reset the outputs are: mode = 0 (off), rst_n = 0, both regulator enables = 0, watchdog period = 0, window bit = 1, and the battery-fail flag is set. One cycle after reset is released, mode becomes 1 (request). No mode returns to 0 except through reset.
- R2: Modes are encoded as off = 0, request = 1, normal = 2, standby = 3, sleep = 4, stop = 5. reg_main_en is 1 in every mode except off and sleep. reg_aux_en is 1 only in normal. rst_n is 0 throughout sleep.
- R3: In request mode, the startup timer counts ms_tick pulses only while no power-on wait and no reset pulse are active. On the REQ_MS-th counted tick without a configuration write, a reset pulse starts and the timer restarts from zero in request mode.
- R4: A write to address 1 (wr_data[PER_W-1:0] = period, wr_data[PER_W] = window) in request mode does three things on the next cycle: the mode becomes normal, wd_load pulses for one cycle, and the period and window outputs take the written values. The same write in normal or standby pulses wd_load but leaves the period and window unchanged.
- R5: vdd_low sampled high drives rst_n to 0 on the following cycle, and it stays 0 for as long as vdd_low stays high.
- R6: After reset, and after a wake from sleep, rst_n stays 0 until vdd_ok is sampled high. rst_n rises in the cycle after that sample, provided no other reset cause is active.
- R7: wdog_expire in normal or standby moves the block to request mode and holds rst_n at 0 for RST_MS counted ticks. In the other modes wdog_expire has no effect.
- R8: lp_valid with lp_mode set to a target is accepted as follows: from normal, targets 3, 4 and 5; from standby, targets 2, 4 and 5. Every other request is ignored.
- R9: wake moves sleep or stop to request mode on the next cycle.
- R10: bat_low sets the battery-fail flag. A read (rd_en) of address 0 returns the flag in rd_data bit DATA_W-1 and then clears it, except when bat_low is high in the same cycle, in which case the flag stays set.
- R11: A read captures data into rd_data on the next cycle. Address 0 gives the current mode in bits [2:0] and the flag in the top bit. Address 1 gives {window, period} in the low bits. Any other address gives 0. All other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| vdd_low | input | 1 | Main supply below reset threshold |
| vdd_ok | input | 1 | Main supply within operating range |
| bat_low | input | 1 | Battery-low comparator output |
| wdog_expire | input | 1 | Watchdog expiry request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | PER_W+1 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Register read address |
| lp_valid | input | 1 | Mode change request strobe |
| lp_mode | input | 3 | Requested target mode |
| wake | input | 1 | Wake event from a low-power mode |
| mode | output | 3 | Current mode code |
| rst_n | output | 1 | Active-low host reset |
| reg_main_en | output | 1 | Main regulator enable |
| reg_aux_en | output | 1 | Auxiliary regulator enable |
| wd_load | output | 1 | Watchdog load/reload pulse |
| wd_period | output | PER_W | Configured watchdog period code |
| wd_window | output | 1 | Configured window (1) or timeout (0) behaviour |
| rd_data | output | DATA_W | Register read data |

## Verification
The hardest case to reach is the wake from sleep while the supply is still out of range. At that point rst_n must stay low even though the reset pulse counter is idle and the mode is already request. The startup timer must also stay frozen so that it cannot add a pulse of its own. The stimulus enters sleep from a configured normal mode, lowers vdd_ok before wake, holds it low for several ticks, and only then raises it. A second case that is hard to reach is a battery-low event in the same cycle as the clearing read. It is driven deliberately after the flag has been cleared once, and the next read must still show the flag set.

// File: rtl/sup_pkg.sv
package sup_pkg;

  typedef enum logic [2:0] {
    MODE_OFF     = 3'd0,
    MODE_REQ     = 3'd1,
    MODE_NORMAL  = 3'd2,
    MODE_STANDBY = 3'd3,
    MODE_SLEEP   = 3'd4,
    MODE_STOP    = 3'd5
  } sup_mode_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_MODECTL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_WDCFG   = 2'd1;

endpackage

// File: rtl/sup_req_timer.sv
module sup_req_timer #(
  parameter int LIMIT = 350
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign expire = run && tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear || expire) begin
      cnt_q <= '0;
    end else if (run && tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int DUR = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic trig,
  input  logic set_por,
  input  logic vdd_ok,
  input  logic vdd_low,
  input  logic sleep_next,
  output logic rst_n,
  output logic hold
);
  localparam int CNT_W = $clog2(DUR + 1);
  localparam logic [CNT_W-1:0] DUR_V = CNT_W'(DUR);

  logic             por_q, por_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    if (set_por)     por_n = 1'b1;
    else if (vdd_ok) por_n = 1'b0;
    else             por_n = por_q;

    if (trig)                     cnt_n = DUR_V;
    else if (cnt_q != '0 && tick) cnt_n = cnt_q - 1'b1;
    else                          cnt_n = cnt_q;
  end

  assign hold = por_q || (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      por_q <= 1'b1;
      cnt_q <= '0;
      rst_n <= 1'b0;
    end else begin
      por_q <= por_n;
      cnt_q <= cnt_n;
      rst_n <= !(vdd_low || por_n || (cnt_n != '0) || sleep_next);
    end
  end
endmodule

// File: rtl/sup_status.sv
module sup_status import sup_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int PER_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bat_low,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [2:0]        mode,
  input  logic [PER_W-1:0]  wd_period,
  input  logic              wd_window,
  output logic [DATA_W-1:0] rd_data,
  output logic              bat_flag
);
  logic [DATA_W-1:0] rd_n;
  logic              clr_rd;

  assign clr_rd = rd_en && (rd_addr == ADDR_MODECTL);

  always_comb begin
    rd_n = '0;
    if (rd_addr == ADDR_MODECTL) begin
      rd_n[2:0]        = mode;
      rd_n[DATA_W-1]   = bat_flag;
    end else if (rd_addr == ADDR_WDCFG) begin
      rd_n[PER_W-1:0]  = wd_period;
      rd_n[PER_W]      = wd_window;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bat_flag <= 1'b1;
      rd_data  <= '0;
    end else begin
      if (bat_low)     bat_flag <= 1'b1;
      else if (clr_rd) bat_flag <= 1'b0;
      if (rd_en)       rd_data  <= rd_n;
    end
  end
endmodule

// File: rtl/sup_mode_seq.sv
module sup_mode_seq import sup_pkg::*; #(
  parameter int REQ_MS = 350,
  parameter int RST_MS = 20,
  parameter int DATA_W = 8,
  parameter int PER_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic              vdd_low,
  input  logic              vdd_ok,
  input  logic              bat_low,
  input  logic              wdog_expire,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PER_W:0]    wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              lp_valid,
  input  logic [2:0]        lp_mode,
  input  logic              wake,
  output logic [2:0]        mode,
  output logic              rst_n,
  output logic              reg_main_en,
  output logic              reg_aux_en,
  output logic              wd_load,
  output logic [PER_W-1:0]  wd_period,
  output logic              wd_window,
  output logic [DATA_W-1:0] rd_data
);
  sup_mode_e mode_q, mode_n;
  sup_mode_e lp_tgt;
  logic      cfg_wr, hold, req_expire, req_run, req_clear;
  logic      trig, set_por, load_n, lp_ok, wd_active;
  logic      bat_flag;

  assign lp_tgt    = sup_mode_e'(lp_mode);
  assign cfg_wr    = wr_en && (wr_addr == ADDR_WDCFG);
  assign wd_active = (mode_q == MODE_NORMAL) || (mode_q == MODE_STANDBY);
  assign req_run   = (mode_q == MODE_REQ) && !hold && !cfg_wr;
  assign req_clear = (mode_q != MODE_REQ) || cfg_wr;

  always_comb begin
    lp_ok = 1'b0;
    if (lp_valid) begin
      case (mode_q)
        MODE_NORMAL:  lp_ok = (lp_tgt == MODE_STANDBY) || (lp_tgt == MODE_SLEEP) ||
                              (lp_tgt == MODE_STOP);
        MODE_STANDBY: lp_ok = (lp_tgt == MODE_NORMAL) || (lp_tgt == MODE_SLEEP) ||
                              (lp_tgt == MODE_STOP);
        default:      lp_ok = 1'b0;
      endcase
    end
  end

  always_comb begin
    mode_n  = mode_q;
    trig    = 1'b0;
    set_por = 1'b0;
    load_n  = 1'b0;
    case (mode_q)
      MODE_OFF: mode_n = MODE_REQ;
      MODE_REQ: begin
        if (cfg_wr) begin
          mode_n = MODE_NORMAL;
          load_n = 1'b1;
        end else if (req_expire) begin
          trig = 1'b1;
        end
      end
      MODE_NORMAL, MODE_STANDBY: begin
        if (wdog_expire) begin
          trig   = 1'b1;
          mode_n = MODE_REQ;
        end else begin
          load_n = cfg_wr;
          if (lp_ok) mode_n = lp_tgt;
        end
      end
      MODE_SLEEP: begin
        if (wake) begin
          mode_n  = MODE_REQ;
          set_por = 1'b1;
        end
      end
      MODE_STOP: if (wake) mode_n = MODE_REQ;
      default:   mode_n = MODE_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MODE_OFF;
      reg_main_en <= 1'b0;
      reg_aux_en  <= 1'b0;
      wd_load     <= 1'b0;
      wd_period   <= '0;
      wd_window   <= 1'b1;
    end else begin
      mode_q      <= mode_n;
      reg_main_en <= (mode_n != MODE_OFF) && (mode_n != MODE_SLEEP);
      reg_aux_en  <= (mode_n == MODE_NORMAL);
      wd_load     <= load_n;
      if (cfg_wr && mode_q == MODE_REQ) begin
        wd_period <= wr_data[PER_W-1:0];
        wd_window <= wr_data[PER_W];
      end
    end
  end

  assign mode = mode_q;

  sup_req_timer #(.LIMIT(REQ_MS)) u_req_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (req_clear),
    .run    (req_run),
    .tick   (ms_tick),
    .expire (req_expire)
  );

  sup_reset_gen #(.DUR(RST_MS)) u_reset_gen (
    .clk        (clk),
    .rst        (rst),
    .tick       (ms_tick),
    .trig       (trig),
    .set_por    (set_por),
    .vdd_ok     (vdd_ok),
    .vdd_low    (vdd_low),
    .sleep_next (mode_n == MODE_SLEEP),
    .rst_n      (rst_n),
    .hold       (hold)
  );

  sup_status #(.DATA_W(DATA_W), .PER_W(PER_W)) u_status (
    .clk       (clk),
    .rst       (rst),
    .bat_low   (bat_low),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .mode      (mode_q),
    .wd_period (wd_period),
    .wd_window (wd_window),
    .rd_data   (rd_data),
    .bat_flag  (bat_flag)
  );
endmodule

// File: rtl/sup_mode_seq_chk.sv
module sup_mode_seq_chk import sup_pkg::*; (
  input logic              clk,
  input logic              rst,
  input logic              vdd_low,
  input logic              wdog_expire,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              bat_low,
  input logic              bat_flag,
  input logic [2:0]        mode,
  input logic              rst_n,
  input logic              reg_main_en,
  input logic              reg_aux_en,
  input logic              wd_load
);
  AST_VDD_LOW_RESET: assert property (@(posedge clk) disable iff (rst)
    vdd_low |=> !rst_n); // R5

  AST_CFG_ENTERS_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_REQ && wr_en && wr_addr == ADDR_WDCFG) |=> (mode == MODE_NORMAL && wd_load)); // R4

  AST_WDOG_TO_REQ: assert property (@(posedge clk) disable iff (rst)
    ((mode == MODE_NORMAL || mode == MODE_STANDBY) && wdog_expire) |=> (mode == MODE_REQ && !rst_n)); // R7

  AST_SLEEP_MAIN_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_SLEEP) |-> (!reg_main_en && !rst_n)); // R2

  AST_REQ_AUX_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_REQ) |-> (reg_main_en && !reg_aux_en)); // R2

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mode <= 3'd5); // R2

  AST_OFF_NOT_REENTERED: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_OFF) |=> (mode != MODE_OFF)); // R1

  AST_BATFLAG_SET: assert property (@(posedge clk) disable iff (rst)
    bat_low |=> bat_flag); // R10
endmodule

bind sup_mode_seq sup_mode_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .vdd_low     (vdd_low),
  .wdog_expire (wdog_expire),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .bat_low     (bat_low),
  .bat_flag    (bat_flag),
  .mode        (mode),
  .rst_n       (rst_n),
  .reg_main_en (reg_main_en),
  .reg_aux_en  (reg_aux_en),
  .wd_load     (wd_load)
);

// File: tb/tb_sup_mode_seq.sv
`timescale 1ns/1ps
module tb_sup_mode_seq;
  localparam int REQ_MS = 6;
  localparam int RST_MS = 3;
  localparam int DATA_W = 8;
  localparam int PER_W  = 2;
  localparam int TDIV   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0;
  logic vdd_low = 1'b0, vdd_ok = 1'b0, bat_low = 1'b0, wdog_expire = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, lp_valid = 1'b0, wake = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [PER_W:0] wr_data = '0;
  logic [2:0] lp_mode = '0;
  logic [2:0] mode;
  logic rst_n, reg_main_en, reg_aux_en, wd_load, wd_window;
  logic [PER_W-1:0] wd_period;
  logic [DATA_W-1:0] rd_data;

  int n_chk = 0, n_fail = 0, tdiv = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sup_mode_seq #(.REQ_MS(REQ_MS), .RST_MS(RST_MS), .DATA_W(DATA_W), .PER_W(PER_W)) dut (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .vdd_low(vdd_low), .vdd_ok(vdd_ok),
    .bat_low(bat_low), .wdog_expire(wdog_expire), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .lp_valid(lp_valid),
    .lp_mode(lp_mode), .wake(wake), .mode(mode), .rst_n(rst_n),
    .reg_main_en(reg_main_en), .reg_aux_en(reg_aux_en), .wd_load(wd_load),
    .wd_period(wd_period), .wd_window(wd_window), .rd_data(rd_data)
  );

  always @(negedge clk) begin
    tdiv    <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    ms_tick <= (tdiv == TDIV - 1);
  end

  // Behavioural reference model, updated on each rising edge
  int m_mode, m_por, m_cnt, m_req, m_rstn, m_flag, m_rd, m_load, m_per, m_win, m_main, m_aux;
  int nm; bit trig, setpor, hold, cfg, legal;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_por = 1; m_cnt = 0; m_req = 0; m_rstn = 0; m_flag = 1;
      m_rd = 0; m_load = 0; m_per = 0; m_win = 1; m_main = 0; m_aux = 0;
    end else begin
      nm = m_mode; trig = 0; setpor = 0; m_load = 0;
      hold = (m_por != 0) || (m_cnt != 0);
      cfg  = wr_en && (wr_addr == 2'd1);
      legal = lp_valid && ((m_mode == 2 && lp_mode inside {3'd3, 3'd4, 3'd5}) ||
                           (m_mode == 3 && lp_mode inside {3'd2, 3'd4, 3'd5}));
      if (rd_en)
        m_rd = (rd_addr == 2'd0) ? ((m_flag << 7) | m_mode) :
               (rd_addr == 2'd1) ? ((m_win << 2) | m_per) : 0;
      if (bat_low) m_flag = 1;
      else if (rd_en && rd_addr == 2'd0) m_flag = 0;
      case (m_mode)
        0: nm = 1;
        1: if (cfg) begin
             nm = 2; m_load = 1; m_per = int'(wr_data[1:0]); m_win = int'(wr_data[2]); m_req = 0;
           end else if (!hold && ms_tick) begin
             if (m_req == REQ_MS - 1) begin trig = 1; m_req = 0; end
             else m_req++;
           end
        2, 3: if (wdog_expire) begin trig = 1; nm = 1; end
              else begin m_load = cfg; if (legal) nm = int'(lp_mode); end
        4: if (wake) begin nm = 1; setpor = 1; end
        5: if (wake) nm = 1;
        default: nm = 0;
      endcase
      if (m_mode != 1) m_req = 0;
      if (setpor) m_por = 1; else if (vdd_ok) m_por = 0;
      if (trig) m_cnt = RST_MS; else if (m_cnt != 0 && ms_tick) m_cnt--;
      m_mode = nm;
      m_main = (nm != 0 && nm != 4);
      m_aux  = (nm == 2);
      m_rstn = !(vdd_low || m_por != 0 || m_cnt != 0 || nm == 4);
    end
  end

  task automatic check_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check_eq("R2 mode vs model", int'(mode), m_mode);
    check_eq("R6 rst_n vs model", int'(rst_n), m_rstn);
    check_eq("R2 reg_main_en vs model", int'(reg_main_en), m_main);
    check_eq("R2 reg_aux_en vs model", int'(reg_aux_en), m_aux);
    check_eq("R4 wd_load vs model", int'(wd_load), m_load);
    check_eq("R4 wd_period vs model", int'(wd_period), m_per);
    check_eq("R4 wd_window vs model", int'(wd_window), m_win);
    check_eq("R10 rd_data vs model", int'(rd_data), m_rd);
  endtask

  task automatic wait_rst_high();
    for (int i = 0; i < 60 && rst_n !== 1'b1; i++) step();
  endtask

  task automatic cfg_write(input logic [PER_W:0] d);
    wr_en = 1; wr_addr = 2'd1; wr_data = d;
    step();
    wr_en = 0;
  endtask

  task automatic go_mode(input logic [2:0] m);
    lp_valid = 1; lp_mode = m;
    step();
    lp_valid = 0;
  endtask

  task automatic rd(input logic [1:0] a);
    rd_en = 1; rd_addr = a;
    step();
    rd_en = 0;
  endtask

  initial begin
    bit seen;
    repeat (3) step();
    // R1 reset state
    check_eq("R1 mode at reset", int'(mode), 0);
    check_eq("R1 rst_n at reset", int'(rst_n), 0);
    check_eq("R1 main enable at reset", int'(reg_main_en), 0);
    check_eq("R1 window at reset", int'(wd_window), 1);
    check_eq("R1 period at reset", int'(wd_period), 0);
    rst = 0;
    step();
    check_eq("R1 request after reset", int'(mode), 1);
    // R6 power-on wait
    repeat (5) step();
    check_eq("R6 held while supply not ok", int'(rst_n), 0);
    vdd_ok = 1;
    step();
    check_eq("R6 released after vdd_ok", int'(rst_n), 1);
    // R3 startup timeout
    seen = 0;
    for (int i = 0; i < 60; i++) begin
      step();
      if (rst_n == 1'b0) begin seen = 1; break; end
    end
    check_eq("R3 timeout reset pulse", int'(seen), 1);
    check_eq("R3 stays in request", int'(mode), 1);
    wait_rst_high();
    // R4 configuration
    cfg_write(3'b010);
    check_eq("R4 normal after config", int'(mode), 2);
    check_eq("R4 load pulse", int'(wd_load), 1);
    check_eq("R4 period latched", int'(wd_period), 2);
    check_eq("R4 window latched", int'(wd_window), 0);
    check_eq("R2 aux enabled in normal", int'(reg_aux_en), 1);
    step();
    check_eq("R4 load one cycle", int'(wd_load), 0);
    cfg_write(3'b101);
    check_eq("R4 reload pulse in normal", int'(wd_load), 1);
    check_eq("R4 period unchanged", int'(wd_period), 2);
    // R5 undervoltage
    vdd_low = 1;
    step();
    check_eq("R5 low on undervoltage", int'(rst_n), 0);
    step();
    vdd_low = 0;
    step();
    check_eq("R5 released", int'(rst_n), 1);
    // R8 transitions
    go_mode(3'd1);
    check_eq("R8 illegal target ignored", int'(mode), 2);
    go_mode(3'd3);
    check_eq("R8 standby entered", int'(mode), 3);
    check_eq("R2 aux off in standby", int'(reg_aux_en), 0);
    // R7 watchdog expiry in standby
    wdog_expire = 1;
    step();
    wdog_expire = 0;
    check_eq("R7 request after expiry", int'(mode), 1);
    check_eq("R7 reset low after expiry", int'(rst_n), 0);
    wait_rst_high();
    cfg_write(3'b110);
    go_mode(3'd5);
    check_eq("R8 stop entered", int'(mode), 5);
    wdog_expire = 1;
    step();
    wdog_expire = 0;
    check_eq("R7 expiry ignored in stop", int'(mode), 5);
    check_eq("R7 no reset in stop", int'(rst_n), 1);
    wake = 1;
    step();
    wake = 0;
    check_eq("R9 wake from stop", int'(mode), 1);
    cfg_write(3'b110);
    go_mode(3'd4);
    check_eq("R8 sleep entered", int'(mode), 4);
    check_eq("R2 main off in sleep", int'(reg_main_en), 0);
    check_eq("R2 reset low in sleep", int'(rst_n), 0);
    vdd_ok = 0;
    wake = 1;
    step();
    wake = 0;
    check_eq("R9 wake from sleep", int'(mode), 1);
    repeat (12) step();
    check_eq("R6 held after sleep wake", int'(rst_n), 0);
    vdd_ok = 1;
    step();
    check_eq("R6 released after sleep wake", int'(rst_n), 1);
    cfg_write(3'b110);
    // R10 / R11 battery flag and reads
    rd(2'd0);
    check_eq("R11 mode control read with flag", int'(rd_data), 8'h82);
    rd(2'd0);
    check_eq("R10 flag cleared by read", int'(rd_data), 8'h02);
    bat_low = 1;
    step();
    bat_low = 0;
    rd(2'd0);
    check_eq("R10 flag set by bat_low", int'(rd_data), 8'h82);
    bat_low = 1; rd_en = 1; rd_addr = 2'd0;
    step();
    bat_low = 0; rd_en = 0;
    rd(2'd0);
    check_eq("R10 set wins over clear", int'(rd_data), 8'h82);
    rd(2'd1);
    check_eq("R11 config read", int'(rd_data), 8'h06);
    rd(2'd3);
    check_eq("R11 unused address reads zero", int'(rd_data), 0);
    repeat (5) step();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule